// File: doc/BRIEF.md
# Cache-Line Barrier Filter Unit

This unit sits next to a shared cache controller and lets a group of up to `NTHR` threads meet at a barrier without any dedicated synchronization wiring. Each participating thread owns two cache lines: an arrival line and an exit line. A thread signals arrival by invalidating its arrival line. It then issues a fill for that same line. The unit withholds that fill until every participating thread has arrived, so the thread stalls. Once the last thread arrives, all withheld fills are answered. Each thread then invalidates its exit line, which makes it eligible for the next barrier.

All arrival lines share one stored tag and all exit lines share another. The upper line-address bits are compared with the tags, and the low `log2(NTHR)` bits pick the thread entry. Each entry has a three-state machine (waiting, blocked, serving), a pending-fill bit, the ID of the held fill and a timeout counter. Requests that break the protocol are reported on an error output and leave the thread's state alone. A fill that has been held for longer than a programmable limit is answered with an error flag set in its response.

Configuration uses write-only register offsets. Offset 0 holds the arrival tag, offset 1 the exit tag and offset 3 the timeout limit. Writing the participant count to offset 2 arms the barrier: the arrival count goes to zero, entries below the count become valid, and every entry goes to waiting with no fill pending.

Top module: `barrier_gate`

## Requirements
- R1: After reset, and after any write of the participant count (offset 2), the arrival count is zero, no fill is pending, and every entry with index below the count is valid and waiting. No grant and no error is produced without a request.
- R2: A request matches thread t when line bits [ADDR_W-1:log2(NTHR)] equal the arrival tag (offset 0) or the exit tag (offset 1) and line bits [log2(NTHR)-1:0] equal t. Every error and grant refers to thread t.
- R3: An arrival invalidate to a waiting thread moves it to blocked and raises the arrival count by one, with no output. While fewer than the participant count have arrived, nothing is released.
- R4: A fill to the arrival line of a blocked thread gets no response. The thread stays blocked, and its pending bit is set together with the request ID.
- R5: An arrival invalidate that finds the count at participants−1 moves every valid thread to serving and clears the count. Pending fills are then granted one per cycle in ascending thread index, starting one cycle after that request's edge, each carrying its held ID with the error flag 0.
- R6: A fill to the arrival line of a serving thread is granted on the next cycle with its own request ID and the error flag 0.
- R7: An exit invalidate to a serving thread returns it to waiting, and the next barrier round behaves like the first one.
- R8: err_valid pulses one cycle after a bad request, with err_thread = t and err_kind as follows: 1 = fill while waiting; 2 = arrival invalidate while blocked or serving; 3 = exit invalidate while waiting or blocked. The thread's state does not change.
- R9: A fill held for L cycles (L = offset 3) is answered L+1 cycles after its request edge, with its ID and grant_err = 1. The thread stays blocked with no fill pending.
- R10: Requests with neither tag, or to an entry at or above the participant count, produce no grant and no error, and change no state.
- R11: A serving thread never goes straight to blocked. An arrival invalidate while serving is flagged with kind 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_fill | input | 1 | 1 = fill, 0 = invalidate |
| req_line | input | ADDR_W | Cache-line address |
| req_id | input | ID_W | Requester tag returned with a grant |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register offset: 0 arrival tag, 1 exit tag, 2 count and arm, 3 timeout limit |
| cfg_wdata | input | ADDR_W-log2(NTHR) | Write data, low bits used for narrower registers |
| grant_valid | output | 1 | Fill response issued |
| grant_id | output | ID_W | ID of the answered fill |
| grant_err | output | 1 | Response carries the timeout error code |
| err_valid | output | 1 | Protocol violation seen |
| err_kind | output | 2 | Violation type (see R8) |
| err_thread | output | log2(NTHR) | Offending thread entry |

## Verification
A thread state machine that is wrong but not visible on its own shows up at the next request to that thread. A fill returns a grant if the thread is serving, stays silent if it is blocked, and raises error kind 1 if it is waiting. An invalidate exposes the state in the same way through kinds 2 and 3, one cycle after the request. A wrong arrival count shows as a release that comes one arrival early or late, which shows in the timing of the drained grants. A wrong pending bit or held ID shows in the order and IDs of those grants, which come on consecutive cycles. A timer that is off by any amount moves the error-flagged grant away from exactly L+1 cycles after its fill.

// File: rtl/barrier_pkg.sv
// Shared types for the barrier filter: per-thread state and error codes.
package barrier_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_BLOCK = 2'd1,
        ST_SERVE = 2'd2
    } thr_state_t;

    typedef enum logic [1:0] {
        ERR_NONE          = 2'd0,
        ERR_EARLY_FILL    = 2'd1,
        ERR_REPEAT_ARRIVE = 2'd2,
        ERR_EARLY_EXIT    = 2'd3
    } err_kind_t;

    localparam logic [1:0] CFG_ARR_TAG  = 2'd0;
    localparam logic [1:0] CFG_EXIT_TAG = 2'd1;
    localparam logic [1:0] CFG_COUNT    = 2'd2;
    localparam logic [1:0] CFG_LIMIT    = 2'd3;
endpackage

// File: rtl/barrier_decode.sv
// Splits a line address into tag and thread index and compares the tag with
// the arrival and exit tags. Purely combinational; assumes the two tags differ.
module barrier_decode #(
    parameter int ADDR_W = 16,
    parameter int TIDX_W = 2,
    localparam int TAG_W = ADDR_W - TIDX_W
) (
    input  logic [ADDR_W-1:0] line,
    input  logic [TAG_W-1:0]  arr_tag,
    input  logic [TAG_W-1:0]  exit_tag,
    output logic              is_arr,
    output logic              is_exit,
    output logic [TIDX_W-1:0] idx
);
    // tag compare and index extraction
    always_comb begin
        idx     = line[TIDX_W-1:0];
        is_arr  = (line[ADDR_W-1:TIDX_W] == arr_tag);
        is_exit = (line[ADDR_W-1:TIDX_W] == exit_tag);
    end
endmodule

// File: rtl/barrier_entry.sv
// One thread entry: three-state machine, pending-fill bit, held request ID
// and timeout counter. The inputs are already qualified for this entry by the
// top level (index match, valid). Assumes at most one request per cycle.
module barrier_entry
    import barrier_pkg::*;
#(
    parameter int ID_W = 4,
    parameter int TO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             arm,
    input  logic             release_all,
    input  logic             arr_inv,
    input  logic             arr_fill,
    input  logic             exit_inv,
    input  logic             bad_req,
    input  logic             grant_me,
    input  logic [ID_W-1:0]  req_id,
    input  logic [TO_W-1:0]  to_limit,
    output thr_state_t       st,
    output logic             pend,
    output logic             ready,
    output logic             expired,
    output logic [ID_W-1:0]  held_id
);
    logic [TO_W-1:0] tmr;

    // flags for the grant picker
    always_comb begin
        expired = pend && (st == ST_BLOCK) && (tmr == to_limit);
        ready   = pend && ((st == ST_SERVE) || expired);
    end

    // state machine transitions
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            st <= ST_WAIT;
        end else if (release_all && valid) begin
            st <= ST_SERVE;
        end else if (arr_inv && st == ST_WAIT) begin
            st <= ST_BLOCK;
        end else if (exit_inv && st == ST_SERVE) begin
            st <= ST_WAIT;
        end
    end

    // pending bit, held ID and timeout counter
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            pend    <= 1'b0;
            tmr     <= '0;
            held_id <= '0;
        end else if (arr_fill && st == ST_BLOCK) begin
            pend    <= 1'b1;
            tmr     <= '0;
            held_id <= req_id;
        end else if ((arr_fill || exit_inv) && st == ST_SERVE) begin
            pend <= 1'b0;
        end else if (grant_me) begin
            pend <= 1'b0;
        end else if (pend && tmr != to_limit) begin
            tmr <= tmr + 1'b1;
        end
    end

    AST_NO_SERVE_TO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_SERVE |=> st != ST_BLOCK); // R11
    AST_PEND_NOT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> st != ST_WAIT); // R4
    AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req && !arm |=> st == $past(st)); // R8
    AST_INVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (st == ST_WAIT && !pend)); // R10
endmodule

// File: rtl/barrier_pick.sv
// Fixed-priority picker: selects the lowest-index ready entry each cycle.
module barrier_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     onehot,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest index wins
    always_comb begin
        onehot = '0;
        any    = 1'b0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                any       = 1'b1;
                idx       = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/barrier_gate.sv
// Barrier filter for one barrier of up to NTHR threads. Watches invalidates
// and fills beside a shared cache, withholds arrival-line fills until all
// participants have arrived, then grants them in ascending thread order.
// Assumes NTHR is a power of two and at most one request per cycle.
module barrier_gate
    import barrier_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int TO_W   = 8,
    localparam int TIDX_W = $clog2(NTHR),
    localparam int TAG_W  = ADDR_W - TIDX_W,
    localparam int CNT_W  = TIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_fill,
    input  logic [ADDR_W-1:0] req_line,
    input  logic [ID_W-1:0]   req_id,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [TAG_W-1:0]  cfg_wdata,
    output logic              grant_valid,
    output logic [ID_W-1:0]   grant_id,
    output logic              grant_err,
    output logic              err_valid,
    output logic [1:0]        err_kind,
    output logic [TIDX_W-1:0] err_thread
);
    logic [TAG_W-1:0]  arr_tag, exit_tag;
    logic [CNT_W-1:0]  num_thr, arr_cnt;
    logic [TO_W-1:0]   to_limit;
    logic              arm;

    logic              is_arr, is_exit;
    logic [TIDX_W-1:0] idx;
    logic [NTHR-1:0]   valid_vec, ready_vec, expired_vec, grant_me;
    thr_state_t        st_arr   [NTHR];
    logic [ID_W-1:0]   held_arr [NTHR];
    logic [NTHR-1:0]   pend_vec;

    logic              hit, arr_inv_hit, arr_fill_hit, exit_inv_hit;
    logic              release_all, immediate;
    thr_state_t        cur_st;
    err_kind_t         err_now;
    logic [NTHR-1:0]   pick_onehot;
    logic              pick_any;
    logic [TIDX_W-1:0] pick_idx;

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_tag  <= '0;
            exit_tag <= '1;
            num_thr  <= '0;
            to_limit <= '1;
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_ARR_TAG:  arr_tag  <= cfg_wdata;
                CFG_EXIT_TAG: exit_tag <= cfg_wdata;
                CFG_COUNT:    num_thr  <= cfg_wdata[CNT_W-1:0];
                default:      to_limit <= cfg_wdata[TO_W-1:0];
            endcase
        end
    end

    assign arm = cfg_we && (cfg_addr == CFG_COUNT);

    barrier_decode #(.ADDR_W(ADDR_W), .TIDX_W(TIDX_W)) u_dec (
        .line(req_line), .arr_tag(arr_tag), .exit_tag(exit_tag),
        .is_arr(is_arr), .is_exit(is_exit), .idx(idx)
    );

    // request classification and protocol check
    always_comb begin
        cur_st       = st_arr[idx];
        hit          = req_valid && (is_arr || is_exit) && valid_vec[idx];
        arr_inv_hit  = hit && is_arr && !req_is_fill;
        arr_fill_hit = hit && is_arr && req_is_fill;
        exit_inv_hit = hit && !is_arr && is_exit && !req_is_fill;
        release_all  = arr_inv_hit && (cur_st == ST_WAIT) &&
                       (arr_cnt == num_thr - CNT_W'(1));
        immediate    = arr_fill_hit && (cur_st == ST_SERVE);
        err_now      = ERR_NONE;
        if (arr_fill_hit && cur_st == ST_WAIT)
            err_now = ERR_EARLY_FILL;
        else if (arr_inv_hit && cur_st != ST_WAIT)
            err_now = ERR_REPEAT_ARRIVE;
        else if (exit_inv_hit && cur_st != ST_SERVE)
            err_now = ERR_EARLY_EXIT;
    end

    // arrival counter
    always_ff @(posedge clk) begin
        if (!rst_n || arm)
            arr_cnt <= '0;
        else if (release_all)
            arr_cnt <= '0;
        else if (arr_inv_hit && cur_st == ST_WAIT)
            arr_cnt <= arr_cnt + 1'b1;
    end

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        logic sel;
        assign sel          = (idx == TIDX_W'(g));
        assign valid_vec[g] = (CNT_W'(g) < num_thr);
        barrier_entry #(.ID_W(ID_W), .TO_W(TO_W)) u_ent (
            .clk(clk), .rst_n(rst_n), .valid(valid_vec[g]), .arm(arm),
            .release_all(release_all),
            .arr_inv(arr_inv_hit && sel), .arr_fill(arr_fill_hit && sel),
            .exit_inv(exit_inv_hit && sel),
            .bad_req((err_now != ERR_NONE) && sel),
            .grant_me(grant_me[g]), .req_id(req_id), .to_limit(to_limit),
            .st(st_arr[g]), .pend(pend_vec[g]), .ready(ready_vec[g]),
            .expired(expired_vec[g]), .held_id(held_arr[g])
        );
    end

    barrier_pick #(.N(NTHR), .IDX_W(TIDX_W)) u_pick (
        .req(ready_vec), .onehot(pick_onehot), .any(pick_any), .idx(pick_idx)
    );

    assign grant_me = immediate ? '0 : pick_onehot;

    // fill response register: immediate grant wins over drained ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_id    <= '0;
            grant_err   <= 1'b0;
        end else begin
            grant_valid <= immediate || pick_any;
            grant_id    <= immediate ? req_id : held_arr[pick_idx];
            grant_err   <= !immediate && pick_any && expired_vec[pick_idx];
        end
    end

    // error report register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid  <= 1'b0;
            err_kind   <= ERR_NONE;
            err_thread <= '0;
        end else begin
            err_valid  <= (err_now != ERR_NONE);
            err_kind   <= err_now;
            err_thread <= idx;
        end
    end

    AST_CNT_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        num_thr != '0 |-> arr_cnt < num_thr); // R3
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_me)); // R5
    AST_UNMATCHED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !hit && !pick_any |=> !grant_valid && !err_valid); // R10
    AST_IMMEDIATE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        immediate |=> grant_valid && !grant_err && grant_id == $past(req_id)); // R6
endmodule

// File: tb/barrier_gate_test.sv
`timescale 1ns/1ps
module barrier_gate_test;
    localparam int NTHR = 4, ADDR_W = 16, ID_W = 4, TO_W = 8;
    localparam logic [13:0] ATAG = 14'h0A5, XTAG = 14'h1C3, OTAG = 14'h2BC;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_is_fill = 0, cfg_we = 0;
    logic [ADDR_W-1:0] req_line = '0;
    logic [ID_W-1:0] req_id = '0;
    logic [1:0] cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic grant_valid, grant_err, err_valid;
    logic [ID_W-1:0] grant_id;
    logic [1:0] err_kind, err_thread;

    int checks = 0, failures = 0, cyc = 0;
    int g_cnt = 0, e_cnt = 0;
    int g_id [16], g_err [16], g_cyc [16], e_kind [16], e_thr [16];

    barrier_gate #(.NTHR(NTHR), .ADDR_W(ADDR_W), .ID_W(ID_W), .TO_W(TO_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_fill(req_is_fill),
        .req_line(req_line), .req_id(req_id), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .grant_valid(grant_valid), .grant_id(grant_id),
        .grant_err(grant_err), .err_valid(err_valid), .err_kind(err_kind),
        .err_thread(err_thread));

    always #2 clk = ~clk;

    // record outputs just after each edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (grant_valid && g_cnt < 16) begin
            g_id[g_cnt] = grant_id; g_err[g_cnt] = grant_err; g_cyc[g_cnt] = cyc; g_cnt++;
        end
        if (err_valid && e_cnt < 16) begin
            e_kind[e_cnt] = err_kind; e_thr[e_cnt] = err_thread; e_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] aline(input int t);
        return {ATAG, 2'(t)};
    endfunction
    function automatic logic [ADDR_W-1:0] xline(input int t);
        return {XTAG, 2'(t)};
    endfunction
    // index of the n-th set bit of mask, counting up from bit 0
    function automatic int nth_set(input int mask, input int n);
        int seen = 0;
        for (int i = 0; i < NTHR; i++)
            if (mask[i]) begin
                if (seen == n) return i;
                seen++;
            end
        return -1;
    endfunction

    task automatic clr();
        g_cnt = 0; e_cnt = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic cfg(input logic [1:0] a, input int d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = 14'(d);
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
    endtask
    task automatic send(input bit fill, input logic [ADDR_W-1:0] line, input int id);
        req_valid = 1; req_is_fill = fill; req_line = line; req_id = ID_W'(id);
        @(posedge clk); @(negedge clk);
        req_valid = 0;
    endtask
    task automatic expect_err(input string req, input int kind, input int thr);
        check(req, e_cnt, 1);
        if (e_cnt == 1) begin
            check(req, e_kind[0], kind);
            check(req, e_thr[0], thr);
        end
        clr();
    endtask

    initial begin
        int ret, n, pmask;
        int order [4];
        int ids [4];
        void'($urandom(1234));
        idle(4);
        rst_n = 1;
        idle(3);
        check("R1 reset no grant", g_cnt, 0);
        check("R1 reset no error", e_cnt, 0);
        cfg(2'd0, ATAG); cfg(2'd1, XTAG); cfg(2'd3, 200); cfg(2'd2, 2);
        clr();

        // R10: foreign tag and invalid entry ignored
        send(1, {OTAG, 2'd0}, 1); send(0, {OTAG, 2'd0}, 1);
        send(0, aline(3), 1); send(1, aline(3), 2); idle(3);
        check("R10 unmatched no grant", g_cnt, 0);
        check("R10 unmatched no error", e_cnt, 0);
        // R8/R2: thread 0 still waiting
        send(1, aline(0), 1); expect_err("R8 fill while waiting", 1, 0);
        send(0, xline(0), 1); expect_err("R8 exit while waiting", 3, 0);
        send(0, aline(0), 1); idle(2);
        check("R3 arrival silent", e_cnt + g_cnt, 0);
        send(0, aline(0), 1); expect_err("R8 repeat arrival", 2, 0);
        send(0, xline(0), 1); expect_err("R8 exit while blocked", 3, 0);
        send(1, aline(0), 9); idle(4);
        check("R4 blocked fill withheld", g_cnt, 0);
        send(0, aline(1), 1); ret = cyc; idle(3);
        check("R5 release grant count", g_cnt, 1);
        check("R5 release grant id", g_id[0], 9);
        check("R5 release grant timing", g_cyc[0] - ret, 1);
        check("R5 release no err flag", g_err[0], 0);
        clr();
        send(0, aline(0), 1); expect_err("R11 arrival while serving", 2, 0);
        send(1, aline(1), 3);
        check("R6 immediate grant", g_cnt, 1);
        check("R6 immediate id", g_id[0], 3);
        clr();
        send(0, xline(0), 0); send(0, xline(1), 0);
        check("R7 exit no error", e_cnt, 0);
        send(1, aline(1), 2); expect_err("R7 back to waiting", 1, 1);
        send(0, aline(0), 0); send(0, aline(1), 0); send(1, aline(0), 4);
        check("R7 second round grant", g_cnt, 1);
        check("R7 second round id", g_id[0], 4);
        send(0, xline(0), 0); send(0, xline(1), 0); clr();

        // R5 ascending drain with four threads
        cfg(2'd2, 4);
        send(0, aline(3), 0); send(1, aline(3), 13);
        send(0, aline(1), 0); send(1, aline(1), 11);
        send(0, aline(2), 0); send(1, aline(2), 12); idle(3);
        check("R3 no release before last", g_cnt, 0);
        send(0, aline(0), 0); ret = cyc; idle(6);
        check("R5 drain count", g_cnt, 3);
        for (int j = 0; j < 3; j++) begin
            check("R5 drain order", g_id[j], 11 + j);
            check("R5 drain one per cycle", g_cyc[j] - ret, 1 + j);
        end
        clr();

        // R9 timeout
        cfg(2'd3, 6); cfg(2'd2, 2);
        send(0, aline(0), 0); send(1, aline(0), 5); ret = cyc; idle(12);
        check("R9 timeout grant", g_cnt, 1);
        check("R9 timeout id", g_id[0], 5);
        check("R9 timeout flag", g_err[0], 1);
        check("R9 timeout delay", g_cyc[0] - ret, 7);
        clr();
        send(0, aline(0), 0); expect_err("R9 stays blocked", 2, 0);
        send(0, aline(1), 0); idle(3);
        check("R9 nothing left pending", g_cnt, 0);
        send(1, aline(0), 6);
        check("R9 serving after release", g_id[0], 6);
        clr(); cfg(2'd3, 200);

        // R5 single participant releases at once
        cfg(2'd2, 1);
        send(0, aline(0), 0); send(1, aline(0), 8);
        check("R5 single thread grant", g_cnt, 1);
        send(0, xline(0), 0);
        check("R7 single exit clean", e_cnt, 0);
        clr();

        // random rounds
        for (int r = 0; r < 30; r++) begin
            n = 2 + int'($urandom % 3);
            cfg(2'd2, n);
            clr(); pmask = 0;
            for (int i = 0; i < n; i++) begin order[i] = i; ids[i] = int'($urandom % 16); end
            for (int i = n - 1; i > 0; i--) begin
                int k, tmp;
                k = int'($urandom % (i + 1));
                tmp = order[i]; order[i] = order[k]; order[k] = tmp;
            end
            for (int k = 0; k < n; k++) begin
                send(0, aline(order[k]), 0);
                if (k < n - 1 && ($urandom % 2) == 1) begin
                    send(1, aline(order[k]), ids[order[k]]);
                    pmask |= (1 << order[k]);
                end
            end
            idle(6);
            check("R5 random drain count", g_cnt, $countones(pmask));
            for (int j = 0; j < $countones(pmask) && j < 16; j++)
                check("R5 random drain id", g_id[j], ids[nth_set(pmask, j)]);
            for (int t = 0; t < n; t++)
                if (!pmask[t]) begin
                    clr(); send(1, aline(t), ids[t]);
                    check("R6 random immediate", g_cnt == 1 ? g_id[0] : -1, ids[t]);
                end
            for (int t = 0; t < n; t++) send(0, xline(t), 0);
            check("R7 random round clean", e_cnt, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule